// File: doc/BRIEF.md
# Single-Bank Chip-Select Generator with Programmable Wait States

This block decodes bus accesses for one peripheral bank. A one-clock request strobe arrives with an address and a read/write flag. The block compares the upper 17 address bits with a programmable base. A mask picks which of those bits take part in the compare, so the bank window is 32 KB or larger. A valid bit gates the whole decode.

On a hit, the active-low chip select asserts in the same clock as the request, with no setup delay. For writes the active-low write strobe asserts with it. The block then counts a programmable number of wait clocks and ends the access with a one-clock transfer acknowledge. If an external acknowledge arrives during the access, it ends the access in that same clock. Both strobes negate after the acknowledge clock; they never negate early.

Setting write protect keeps both strobes high during writes. The write still receives its acknowledge on schedule, and an error flag pulses for one clock alongside that acknowledge.

Top module: `cs_waitgen`

## Requirements
- R1: After reset, cs_n and we_n are 1 and ack and wp_err are 0.
- R2: A request hits when, for every bit i where cfg_mask[i] is 1, addr[15+i] equals cfg_base[i]. Bits whose mask bit is 0 are ignored. A request that misses gives no chip select and no ack.
- R3: While cfg_valid is 0, no request hits, whatever the address is.
- R4: On a hit, cs_n goes low in the clock in which req is high. It stays low through the ack clock and is high in the following clock. With no access in progress and req low, cs_n is high and ack is low.
- R5: With no external acknowledge, ack is high for exactly one clock, cfg_wait+1 clocks after the request clock. A cfg_wait of 0 gives ack in the clock right after the request.
- R6: An ext_ack that is high while an access is in progress raises ack in that same clock and ends the access.
- R7: we_n is low for exactly the clocks in which cs_n is low during an unprotected write. During reads, we_n stays high.
- R8: When cfg_wprot is 1, a write keeps cs_n and we_n high, yet still produces ack on the R5 schedule. wp_err is high only in that ack clock. Reads are not affected by cfg_wprot.
- R9: A req that arrives while an access is in progress is ignored and does not change the ack timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | One-clock request strobe |
| addr | input | 32 | Access address, valid with req |
| wr | input | 1 | 1 = write, 0 = read, valid with req |
| cfg_base | input | 17 | Base value for the upper address bits |
| cfg_mask | input | 17 | 1 = bit takes part in the compare |
| cfg_valid | input | 1 | Bank enable |
| cfg_wprot | input | 1 | Write protect |
| cfg_wait | input | 4 | Number of wait clocks |
| ext_ack | input | 1 | External early acknowledge |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write strobe, active low |
| ack | output | 1 | Transfer acknowledge |
| wp_err | output | 1 | Write-protect violation pulse |

## Verification
The strobes respond combinationally in the request clock. The bench therefore drives inputs on the falling edge and samples cs_n and we_n a short delay later, before the next rising edge. It then samples once per clock on each falling edge, counting clocks from the request. It expects ack and wp_err exactly at count cfg_wait+1, or at the clock in which it raised ext_ack. It checks that cs_n is high again one clock after that. For misses, the bench watches cfg_wait+3 clocks and expects the strobes to stay high and no ack to appear.

// File: rtl/cs_waitgen.sv
module cs_waitgen #(
  parameter int AW = 32,
  parameter int MW = 17,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [MW-1:0] cfg_base,
  input  logic [MW-1:0] cfg_mask,
  input  logic          cfg_valid,
  input  logic          cfg_wprot,
  input  logic [WW-1:0] cfg_wait,
  input  logic          ext_ack,
  output logic          cs_n,
  output logic          we_n,
  output logic          ack,
  output logic          wp_err
);
  logic          busy, blk_q, wr_q;
  logic [WW-1:0] cnt;

  wire hit     = cfg_valid && (((addr[AW-1 -: MW] ^ cfg_base) & cfg_mask) == '0);
  wire start   = req && hit && !busy;
  wire blk_now = wr && cfg_wprot;
  wire done    = busy && (cnt == '0 || ext_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      blk_q <= 1'b0;
      wr_q  <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      blk_q <= blk_now;
      wr_q  <= wr;
      cnt   <= cfg_wait;
    end else if (done) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt   <= cnt - 1'b1;
    end
  end

  assign cs_n   = !((start && !blk_now) || (busy && !blk_q));
  assign we_n   = !((start && wr && !blk_now) || (busy && wr_q && !blk_q));
  assign ack    = done;
  assign wp_err = done && blk_q;
endmodule

module cs_waitgen_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ext_ack,
  input logic cs_n,
  input logic we_n,
  input logic ack,
  input logic wp_err,
  input logic busy
);
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) wp_err |-> (ack && cs_n && we_n)); // R8
  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !cs_n); // R7
  AST_EXT_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && ext_ack) |-> ack); // R6
  AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !req) |-> (cs_n && !ack)); // R4
  AST_ACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !busy); // R9
endmodule

bind cs_waitgen cs_waitgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ext_ack(ext_ack), .cs_n(cs_n),
  .we_n(we_n), .ack(ack), .wp_err(wp_err), .busy(busy)
);

// File: tb/sim_cs_waitgen.sv
`timescale 1ns/1ps
module sim_cs_waitgen;
  logic clk = 0, rst_n = 0, req = 0, wr = 0, cfg_valid = 0, cfg_wprot = 0, ext_ack = 0;
  logic [31:0] addr = '0;
  logic [16:0] cfg_base = '0, cfg_mask = '0;
  logic [3:0]  cfg_wait = '0;
  logic cs_n, we_n, ack, wp_err;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  cs_waitgen u0 (.*);

  typedef struct packed {
    logic [31:0] a; logic w; logic [16:0] b; logic [16:0] m;
    logic v; logic p; logic [3:0] ws; logic hit; logic blk;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'h2000_1234, 1'b0, 17'h04000, 17'h1FFFF, 1'b1, 1'b0, 4'd1,  1'b1, 1'b0},
    '{32'h2000_1234, 1'b1, 17'h04000, 17'h1FFFF, 1'b1, 1'b0, 4'd0,  1'b1, 1'b0},
    '{32'h2000_9234, 1'b0, 17'h04000, 17'h1FFFF, 1'b1, 1'b0, 4'd1,  1'b0, 1'b0},
    '{32'h2000_9234, 1'b0, 17'h04000, 17'h1FFFE, 1'b1, 1'b0, 4'd3,  1'b1, 1'b0},
    '{32'h2000_1234, 1'b1, 17'h04000, 17'h1FFFF, 1'b0, 1'b0, 4'd1,  1'b0, 1'b0},
    '{32'h2000_1234, 1'b1, 17'h04000, 17'h1FFFF, 1'b1, 1'b1, 4'd2,  1'b1, 1'b1},
    '{32'h2000_1234, 1'b0, 17'h04000, 17'h1FFFF, 1'b1, 1'b1, 4'd1,  1'b1, 1'b0},
    '{32'h2000_7FFC, 1'b1, 17'h04000, 17'h1FFFF, 1'b1, 1'b0, 4'd15, 1'b1, 1'b0}
  };

  task automatic chk(input string r, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic start_req(input vec_t t);
    @(negedge clk);
    addr = t.a; wr = t.w; cfg_base = t.b; cfg_mask = t.m;
    cfg_valid = t.v; cfg_wprot = t.p; cfg_wait = t.ws; req = 1;
    #1;
  endtask

  task automatic run_vec(input vec_t t, input string r);
    logic exp_cs, exp_we;
    start_req(t);
    exp_cs = !(t.hit && !t.blk);
    exp_we = !(t.hit && !t.blk && t.w);
    chk({r, " cs in request clock"}, cs_n, exp_cs);
    chk({r, " we in request clock"}, we_n, exp_we);
    for (int k = 1; k <= int'(t.ws) + 3; k++) begin
      @(negedge clk);
      req = 0;
      #1;
      if (t.hit && k <= int'(t.ws) + 1) begin
        chk({r, " cs held"}, cs_n, exp_cs);
        chk({r, " we held"}, we_n, exp_we);
        chk({r, " ack timing"}, ack, k == int'(t.ws) + 1);
        chk({r, " wp_err"}, wp_err, (k == int'(t.ws) + 1) && t.blk);
      end else begin
        chk({r, " cs released"}, cs_n, 1'b1);
        chk({r, " no ack"}, ack, 1'b0);
      end
    end
  endtask

  initial begin
    #5;
    chk("R1 cs_n reset", cs_n, 1'b1);
    chk("R1 we_n reset", we_n, 1'b1);
    chk("R1 ack reset", ack, 1'b0);
    chk("R1 wp_err reset", wp_err, 1'b0);
    @(negedge clk); rst_n = 1;

    run_vec(TBL[0], "R2 R4 R5 hit read");
    run_vec(TBL[1], "R5 R7 write wait0");
    run_vec(TBL[2], "R2 miss");
    run_vec(TBL[3], "R2 masked hit");
    run_vec(TBL[4], "R3 invalid");
    run_vec(TBL[5], "R8 protected write");
    run_vec(TBL[6], "R8 protected read");
    run_vec(TBL[7], "R5 R7 wait15 write");

    begin : r6_ext
      vec_t t = TBL[0];
      t.ws = 4'd6;
      start_req(t);
      @(negedge clk); req = 0; #1;
      chk("R6 no ack before ext", ack, 1'b0);
      @(negedge clk); ext_ack = 1; #1;
      chk("R6 ack on ext_ack", ack, 1'b1);
      chk("R6 cs in ext ack clock", cs_n, 1'b0);
      @(negedge clk); ext_ack = 0; #1;
      chk("R6 cs released after ext", cs_n, 1'b1);
      chk("R6 ack ended", ack, 1'b0);
    end

    begin : r9_busy
      vec_t t = TBL[0];
      t.ws = 4'd3;
      start_req(t);
      @(negedge clk); req = 0; #1;
      @(negedge clk); req = 1; wr = 1; #1;
      chk("R9 second req ignored we", we_n, 1'b1);
      @(negedge clk); req = 0; #1;
      chk("R9 no early ack", ack, 1'b0);
      @(negedge clk); #1;
      chk("R9 ack on original schedule", ack, 1'b1);
      @(negedge clk); #1;
      chk("R9 no second access", cs_n, 1'b1);
    end

    repeat (2) @(negedge clk);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule